// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K bytes. That RAM has a 19-bit address, an 8-bit data bus and three active-low strobes: chip select, write strobe and read enable. The host presents one request at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. Each read returns its byte as a one-cycle response pulse.

The RAM's minimum times are parameters in nanoseconds. They are rounded up to whole clock periods from a clock-period parameter. A grade parameter picks the fast (70 ns) or slow (100 ns) set of limits. The data bus is split at the block edge into an output, an output enable and an input, and the pad ring joins them. A write-protect input holds off new requests, but it does not cut short a cycle that has already started.

Top module: `async_sram_ctl`

## Requirements
- R1: While reset is low and after it is released, chip select, write strobe and read enable are high (inactive), the data driver is off, `rspValid` is low, and `reqReady` is high as long as `wrProtect` is low.
- R2: A read is accepted on a clock edge where `reqValid` and `reqReady` are both high and `reqWrite` is 0. It holds the write strobe high and drives chip select and read enable low. The byte on `ramDqIn` is captured, and `rspValid` pulses high for exactly one cycle, RD clock edges after the accept edge. RD is the rounded-up maximum of the access time and the read cycle time: 4 at the defaults.
- R3: Chip select and read enable stay low through a read for at least the access time (70 ns fast, 100 ns slow) and at least the read-enable-to-data time (35 ns fast, 50 ns slow). The captured byte is therefore the RAM's valid data for the addressed location.
- R4: A write (`reqWrite` = 1) drives chip select and the write strobe low on the accept edge, with the data driver on. Read enable stays high for the whole write. The write strobe stays low for at least the write pulse time (55 ns / 75 ns) and at least the data setup time (30 ns / 40 ns). The data stays unchanged while the strobe is low.
- R5: A write is ended by the write strobe rising while chip select is still low and the data is still driven. Chip select stays low long enough for the write cycle time (70 ns / 100 ns) to be met. At least the write recovery time (5 ns) passes before chip select falls again.
- R6: The RAM address does not change while chip select is low.
- R7: The data driver is on only in write cycles. It is off for at least one clock before read enable falls, and it is never on while read enable is low.
- R8: While `wrProtect` is high, `reqReady` is low and no new cycle starts. A cycle already in progress still completes, and a write in progress still stores its data.
- R9: `reqReady` is low while a cycle is in progress. A request that is not yet accepted starts its cycle only on the first edge where `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Host byte address |
| reqWdata | input | 8 | Host write data |
| reqReady | output | 1 | Controller can accept a request this cycle |
| wrProtect | input | 1 | Blocks the start of new cycles |
| rspValid | output | 1 | One-cycle pulse: read data valid |
| rspRdata | output | 8 | Read data |
| ramAddr | output | 19 | RAM address |
| ramDqOut | output | 8 | Data driven toward the RAM |
| ramDqEn | output | 1 | Enables the data driver |
| ramDqIn | input | 8 | Data from the RAM bus |
| ramCeN | output | 1 | RAM chip select, active low |
| ramWeN | output | 1 | RAM write strobe, active low |
| ramOeN | output | 1 | RAM read enable, active low |

## Verification
A read's byte and its `rspValid` pulse are due exactly RD edges after the accept edge. The bench computes RD from the nanosecond limits and the 20 ns period. The driver task records the expected cycle number next to the expected byte. The monitor compares both on the falling edge after the pulse. The RAM model in the bench counts clock periods since each strobe fell and presents valid data only when those counts satisfy the access limits, so a read that is sampled too early returns a wrong byte. The model also checks the pulse width, setup, recovery, cycle time, address hold and bus ownership at every falling clock edge, in the same cycle in which each of them changes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RECOV = 2'd3
  } ctlState_e;

  // Strobes from the sequencer to the pin datapath; the pin levels follow
  // the state the controller is entering.
  typedef struct packed {
    logic chipEn;
    logic writeEn;
    logic outEn;
    logic driveBus;
    logic loadReq;
    logic captureRd;
  } ctlStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC  = 4,
  parameter int WP_CYC  = 3,
  parameter int REC_CYC = 1,
  parameter int CNT_W   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       wrProtect,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  ctlState_e        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             accept;
  logic             cntDone;

  assign reqReady = (state == ST_IDLE) && !wrProtect;
  assign accept   = reqValid && reqReady;
  assign cntDone  = (cnt == '0);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (reqWrite) begin
            nextState = ST_WRITE;
            nextCnt   = CNT_W'(WP_CYC - 1);
          end else begin
            nextState = ST_READ;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cntDone) nextState = ST_IDLE;
        else         nextCnt   = cnt - CNT_W'(1);
      end
      ST_WRITE: begin
        if (cntDone) begin
          nextState = ST_RECOV;
          nextCnt   = CNT_W'(REC_CYC - 1);
        end else begin
          nextCnt = cnt - CNT_W'(1);
        end
      end
      ST_RECOV: begin
        if (cntDone) nextState = ST_IDLE;
        else         nextCnt   = cnt - CNT_W'(1);
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  always_comb begin
    strobe.chipEn    = (nextState != ST_IDLE);
    strobe.writeEn   = (nextState == ST_WRITE);
    strobe.outEn     = (nextState == ST_READ);
    strobe.driveBus  = (nextState == ST_WRITE) || (nextState == ST_RECOV);
    strobe.loadReq   = accept;
    strobe.captureRd = (state == ST_READ) && cntDone;
  end

  // R8: a protected idle controller stays idle on the next edge
  assert_protect_holds_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wrProtect) |=> (state == ST_IDLE));

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqEn,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramCeN  <= 1'b1;
      ramWeN  <= 1'b1;
      ramOeN  <= 1'b1;
      ramDqEn <= 1'b0;
    end else begin
      ramCeN  <= !strobe.chipEn;
      ramWeN  <= !strobe.writeEn;
      ramOeN  <= !strobe.outEn;
      ramDqEn <= strobe.driveBus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramAddr  <= '0;
      ramDqOut <= '0;
    end else if (strobe.loadReq) begin
      ramAddr  <= reqAddr;
      ramDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.captureRd;
      if (strobe.captureRd) rspRdata <= ramDqIn;
    end
  end

  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> ramOeN);

  assert_we_rises_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> !ramCeN);

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCeN && $past(!ramCeN)) |-> $stable(ramAddr));

  assert_bus_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramOeN) |-> !$past(ramDqEn));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    ramDqEn |-> ramOeN);

  assert_single_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter bit FAST_GRADE    = 1'b1,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              wrProtect,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqEn,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic              ramOeN
);

  // Grade-dependent minimum times in ns
  localparam int T_ACC = FAST_GRADE ? 70 : 100;
  localparam int T_RC  = FAST_GRADE ? 70 : 100;
  localparam int T_OE  = FAST_GRADE ? 35 : 50;
  localparam int T_WP  = FAST_GRADE ? 55 : 75;
  localparam int T_WC  = FAST_GRADE ? 70 : 100;
  localparam int T_DS  = FAST_GRADE ? 30 : 40;
  localparam int T_WR  = 5;

  localparam int RD_CYC = maxOf(maxOf(nsToCycles(T_ACC, CLK_PERIOD_NS),
                                      nsToCycles(T_RC, CLK_PERIOD_NS)),
                                maxOf(nsToCycles(T_OE, CLK_PERIOD_NS), 1));
  localparam int WP_CYC = maxOf(maxOf(nsToCycles(T_WP, CLK_PERIOD_NS),
                                      nsToCycles(T_DS, CLK_PERIOD_NS)), 1);
  localparam int REC_CYC = maxOf(maxOf(nsToCycles(T_WR, CLK_PERIOD_NS), 1),
                                 nsToCycles(T_WC, CLK_PERIOD_NS) - WP_CYC);
  localparam int CNT_MAX = maxOf(maxOf(RD_CYC, WP_CYC), REC_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctlStrobe_t strobe;

  sram_ctl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .CNT_W  (CNT_W)
  ) uFsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .wrProtect(wrProtect),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  sram_ctl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .ramDqIn (ramDqIn),
    .ramAddr (ramAddr),
    .ramDqOut(ramDqOut),
    .ramDqEn (ramDqEn),
    .ramCeN  (ramCeN),
    .ramWeN  (ramWeN),
    .ramOeN  (ramOeN),
    .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

endmodule

// File: tb/async_sram_ctl_test.sv
`timescale 1ns/1ps
module async_sram_ctl_test;

  localparam int P     = 20;
  localparam int T_ACC = 70;
  localparam int T_RC  = 70;
  localparam int T_OE  = 35;
  localparam int T_WP  = 55;
  localparam int T_WC  = 70;
  localparam int T_DS  = 30;
  localparam int T_WR  = 5;
  localparam int RD    = (T_ACC + P - 1) / P;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady;
  logic        wrProtect = 1'b0;
  logic        rspValid;
  logic [7:0]  rspRdata;
  logic [18:0] ramAddr;
  logic [7:0]  ramDqOut;
  logic        ramDqEn;
  logic [7:0]  ramDqIn = 8'hEE;
  logic        ramCeN, ramWeN, ramOeN;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_sram_ctl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .wrProtect(wrProtect), .rspValid(rspValid), .rspRdata(rspRdata),
    .ramAddr(ramAddr), .ramDqOut(ramDqOut), .ramDqEn(ramDqEn),
    .ramDqIn(ramDqIn), .ramCeN(ramCeN), .ramWeN(ramWeN), .ramOeN(ramOeN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioral RAM model with timing checks ----------------
  logic [7:0]  mem [int];
  logic [7:0]  shadow [int];
  int  ceLowCnt = 0, oeLowCnt = 0, weLowCnt = 0, sinceWeRise = 1000;
  bit  prevCeN = 1'b1, prevWeN = 1'b1, cycIsWrite = 1'b0;
  logic [18:0] prevAddr = '0;
  logic [7:0]  prevDq = '0;

  always @(negedge clk) begin
    if (rstN) begin
      // R7: never drive while the RAM may drive
      if (ramDqEn && !ramOeN) check(1'b0, "R7 contention", 1, 0);
      if (!ramOeN && ramDqEn === 1'b0 && prevCeN && !ramCeN && sinceWeRise == 0)
        check(1'b0, "R7 release", 0, 1);
      // R4: read enable high during write
      if (!ramWeN && !ramOeN) check(1'b0, "R4 oe in write", 0, 1);
      // R6: address stable while selected
      if (!ramCeN && !prevCeN && ramAddr != prevAddr)
        check(1'b0, "R6 addr moved", int'(ramAddr), int'(prevAddr));
      if (!ramWeN && !prevWeN && ramDqOut != prevDq)
        check(1'b0, "R4 data moved", int'(ramDqOut), int'(prevDq));
      if (!ramWeN && !ramDqEn) check(1'b0, "R4 data not driven", 0, 1);
      // chip select falls: recovery since last write
      if (prevCeN && !ramCeN) begin
        check(sinceWeRise * P >= T_WR, "R5 recovery", sinceWeRise * P, T_WR);
        cycIsWrite = 1'b0;
      end
      // chip select rises: cycle length
      if (!prevCeN && ramCeN) begin
        if (cycIsWrite) check(ceLowCnt * P >= T_WC, "R5 write cycle", ceLowCnt * P, T_WC);
        else            check(ceLowCnt * P >= T_RC, "R3 read cycle", ceLowCnt * P, T_RC);
      end
      // write strobe rises: end of write
      if (!prevWeN && ramWeN) begin
        check(!ramCeN, "R5 strobe order", int'(ramCeN), 0);
        check(ramDqEn, "R5 data hold", int'(ramDqEn), 1);
        check(weLowCnt * P >= T_WP, "R4 pulse width", weLowCnt * P, T_WP);
        check(weLowCnt * P >= T_DS, "R4 data setup", weLowCnt * P, T_DS);
        if (!ramCeN && ramDqEn) mem[int'(ramAddr)] = ramDqOut;
        sinceWeRise = 0;
      end else if (sinceWeRise < 1000) begin
        sinceWeRise++;
      end
      if (!ramWeN && !ramCeN) cycIsWrite = 1'b1;
    end
    ceLowCnt = ramCeN ? 0 : ceLowCnt + 1;
    oeLowCnt = ramOeN ? 0 : oeLowCnt + 1;
    weLowCnt = ramWeN ? 0 : weLowCnt + 1;
    prevCeN  = ramCeN;
    prevWeN  = ramWeN;
    prevAddr = ramAddr;
    prevDq   = ramDqOut;
    // data valid at the next rising edge only once access limits are met
    if (!ramCeN && !ramOeN && ramWeN && ceLowCnt * P >= T_ACC && oeLowCnt * P >= T_OE)
      ramDqIn = mem.exists(int'(ramAddr)) ? mem[int'(ramAddr)] : 8'h00;
    else
      ramDqIn = 8'hEE;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] data; int due; } exp_t;
  exp_t expQ[$];

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected response", int'(rspRdata), 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspRdata == e.data, "R2/R3 read data", int'(rspRdata), int'(e.data));
        check(cyc == e.due, "R2 response cycle", cyc, e.due);
      end
    end
  end

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int accCyc;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    accCyc = cyc + 1;
    @(negedge clk);
    reqValid = 1'b0;
    // R9: busy right after acceptance
    check(!reqReady, "R9 busy", int'(reqReady), 0);
    if (wr) shadow[int'(a)] = d;
    else begin
      exp_t e;
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      e.due  = accCyc + RD;
      expQ.push_back(e);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check(expQ.size() == 0, "R2 missing response", expQ.size(), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ramCeN && ramWeN && ramOeN, "R1 strobes in reset", {ramCeN, ramWeN, ramOeN}, 3'b111);
    check(!ramDqEn, "R1 driver in reset", int'(ramDqEn), 0);
    check(!rspValid, "R1 rsp in reset", int'(rspValid), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R1 ready after reset", int'(reqReady), 1);
    check(ramCeN && ramWeN && ramOeN && !ramDqEn, "R1 idle pins",
          {ramCeN, ramWeN, ramOeN, ramDqEn}, 4'b1110);

    // R4/R5: writes of several patterns, boundary addresses
    issue(1'b1, 19'h00000, 8'hA5);
    issue(1'b1, 19'h7FFFF, 8'h5A);
    issue(1'b1, 19'h12345, 8'hFF);
    issue(1'b1, 19'h54321, 8'h00);
    // R2/R3: reads, write-then-read turnaround (R7)
    issue(1'b0, 19'h54321, 8'h00);
    issue(1'b0, 19'h00000, 8'h00);
    issue(1'b0, 19'h7FFFF, 8'h00);
    issue(1'b1, 19'h00001, 8'h3C);
    issue(1'b0, 19'h00001, 8'h00);
    issue(1'b0, 19'h12345, 8'h00);
    drain();

    // R8: protect blocks new cycles at the ports
    @(negedge clk); wrProtect = 1'b1;
    @(negedge clk);
    check(!reqReady, "R8 ready under protect", int'(reqReady), 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h00000; reqWdata = 8'h99;
    begin
      bit sawCycle = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!ramCeN || reqReady) sawCycle = 1'b1;
      end
      check(!sawCycle, "R8 no cycle under protect", int'(sawCycle), 0);
    end
    reqValid = 1'b0;
    wrProtect = 1'b0;
    issue(1'b0, 19'h00000, 8'h00);   // still A5, blocked write had no effect
    drain();

    // R8: protect raised during a write lets it finish
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h0ABCD; reqWdata = 8'h77;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; wrProtect = 1'b1;
    shadow[32'h0ABCD] = 8'h77;
    repeat (8) @(negedge clk);
    check(ramCeN && ramWeN && !ramDqEn, "R8 write completed", {ramCeN, ramWeN, ramDqEn}, 3'b110);
    wrProtect = 1'b0;
    issue(1'b0, 19'h0ABCD, 8'h00);
    // R9: request waits while busy, then starts
    issue(1'b1, 19'h00002, 8'hC3);
    issue(1'b0, 19'h00002, 8'h00);
    drain();

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule